// File: doc/BRIEF.md
# Per-Port Frame Arrival Timestamp Latch

This block records when a network frame starts arriving on each of four ports, so that host software can work out how long a frame takes to travel around the ring and back. A free-running local time value (in ticks of the local, drift-controlled clock) is sampled on every start-of-frame strobe into a per-port shadow register. Only a measurement that the host has armed reaches the registers the host can read. The host arms a measurement by writing to the port-0 receive-time register.

After arming, the first frame seen on each port is the measured frame. Its start-of-frame time is held in that port's shadow register and is copied into the port's readable receive-time register on the end-of-frame strobe of that same frame. The host reads the four 32-bit receive-time registers one byte at a time. Reading the low byte freezes the upper bytes, so the value assembled from the four bytes is coherent. The delay arithmetic is done by the host and is not part of this block.

Top module: `rx_arrival_stamp`

## Requirements
- R1: After a synchronous active-low reset, all four receive-time registers read as zero and no port is armed.
- R2: The receive-time register of port p occupies byte addresses 0x900+4p to 0x903+4p, with the least significant byte at the lowest address. A read strobe returns the addressed byte on `rd_data_o` in the following cycle. A read of any address outside 0x900 to 0x90F returns 0x00.
- R3: A write strobe to any of the byte addresses 0x900 to 0x903 arms all four ports. Write strobes to any other address arm nothing. Start-of-frame strobes count toward the measurement only from the cycle after the write.
- R4: The value captured for a port equals `local_time_i` in the cycle in which that port's first start-of-frame strobe after arming is high.
- R5: The captured value becomes the port's receive-time register on the end-of-frame strobe of that frame. A read issued in the cycle after the end-of-frame strobe returns it.
- R6: An end-of-frame strobe on a port that has no armed start-of-frame pending leaves that port's register unchanged.
- R7: A port that sees no frame during a measurement keeps its previous register value while other ports update.
- R8: Frames that arrive while a port is not armed are latched only internally and never change the readable register.
- R9: Reading byte 0 of a register snapshots its upper three bytes. Later reads of bytes 1 to 3 of that port return the snapshot, even if the register has been updated since.
- R10: One arming captures at most one frame per port. A second frame on the same port is ignored until the port is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| local_time_i | input | 32 | Free-running local time in controlled clock ticks |
| sof_i | input | 4 | Per-port start-of-frame strobe, one cycle |
| eof_i | input | 4 | Per-port end-of-frame strobe, one cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write byte address |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 12 | Register read byte address |
| rd_data_o | output | 8 | Read data, valid the cycle after `rd_en_i` |

## Verification
Each result is due a fixed number of edges after its stimulus:
- Arming takes effect one edge after the write.
- The shadow register samples on the edge where the start-of-frame strobe is high.
- The readable register changes on the end-of-frame edge.
- Read data appears one edge after the read strobe.

The bench drives each strobe for exactly one cycle between falling edges and samples `rd_data_o` on the falling edge after the read edge. It leaves at least one idle cycle between arming and the start-of-frame strobe, so each check lands on the cycle in which the result is defined. The snapshot test separates the byte-0 read from the upper-byte reads by a whole new measurement, so a read that is not coherent shows up as wrong upper bytes.

// File: rtl/rxt_pkg.sv
// Shared constants for the frame arrival timestamp latch.
// Assumes the host bus is one byte wide.
package rxt_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxt_arm_decode.sv
// Decodes host write strobes into a one-cycle arm pulse.
// Any byte of the port-0 receive-time register arms a measurement.
// Assumes the register base address is given as a byte address.
module rxt_arm_decode #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BYTES  = 4,
    parameter logic [ADDR_W-1:0] BASE = 12'h900
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    output logic              arm_o
);
    localparam logic [ADDR_W-1:0] LIMIT = BASE + ADDR_W'(BYTES);

    // Range match on the first register only.
    always_comb begin
        arm_o = wr_en_i && (wr_addr_i >= BASE) && (wr_addr_i < LIMIT);
    end
endmodule

// File: rtl/rxt_port_capture.sv
// One port's capture path. Every start-of-frame strobe samples local time
// into a shadow register. The first start-of-frame after arming marks a
// pending capture, and the end-of-frame strobe that follows publishes the
// shadow value.
// Assumes strobes are single-cycle. If start and end of frame arrive in
// the same cycle, the end belongs to the earlier frame.
module rxt_port_capture #(
    parameter int unsigned TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] local_time_i,
    input  logic              sof_i,
    input  logic              eof_i,
    input  logic              arm_i,
    output logic [TIME_W-1:0] rx_time_o
);
    logic              arm_q;
    logic              pend_q;
    logic [TIME_W-1:0] shadow_q;
    logic [TIME_W-1:0] rx_time_q;

    // Arm flag: set by the host, consumed by the first start-of-frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          arm_q <= 1'b0;
        else if (arm_i)      arm_q <= 1'b1;
        else if (sof_i)      arm_q <= 1'b0;
    end

    // Pending flag: an armed frame has started and not yet ended.
    always_ff @(posedge clk) begin
        if (!rst_n)              pend_q <= 1'b0;
        else if (sof_i && arm_q) pend_q <= 1'b1;
        else if (eof_i)          pend_q <= 1'b0;
    end

    // Internal latch of every start-of-frame time.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_q <= '0;
        else if (sof_i) shadow_q <= local_time_i;
    end

    // Visible register: loaded only when an armed frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n)               rx_time_q <= '0;
        else if (eof_i && pend_q) rx_time_q <= shadow_q;
    end

    assign rx_time_o = rx_time_q;

    // R8: the visible value moves only when a pending frame ends.
    a_r8_quiet_without_publish: assert property (@(posedge clk) disable iff (!rst_n)
        !(eof_i && pend_q) |=> $stable(rx_time_q));

    // R6: an end-of-frame with nothing pending changes nothing.
    a_r6_orphan_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_i && !pend_q) |=> $stable(rx_time_q));

    // R10: a capture can begin only from the armed state.
    a_r10_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(arm_q));
endmodule

// File: rtl/rxt_read_port.sv
// Byte-wide read path over the receive-time registers. A read of byte 0
// returns the low byte and freezes the upper bytes of that port. Reads
// of higher bytes return the frozen copy.
// Assumes NUM_PORTS and the register size are powers of two and that BASE
// is aligned to the size of the whole window.
module rxt_read_port
    import rxt_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned TIME_W    = 32,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE = 12'h900
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [TIME_W-1:0] rx_time_i [NUM_PORTS],
    output byte_t             rd_data_o
);
    localparam int unsigned BYTES  = TIME_W / BYTE_W;
    localparam int unsigned LANE_W = $clog2(BYTES);
    localparam int unsigned PORT_W = $clog2(NUM_PORTS);
    localparam int unsigned HI_LSB = LANE_W + PORT_W;
    localparam int unsigned SNAP_W = TIME_W - BYTE_W;

    logic [SNAP_W-1:0] snap_q [NUM_PORTS];
    logic              hit;
    logic [PORT_W-1:0] port_sel;
    logic [LANE_W-1:0] lane_sel;
    logic [LANE_W-1:0] upper_sel;

    // Address split into window match, port index and byte lane.
    always_comb begin
        hit       = (rd_addr_i[ADDR_W-1:HI_LSB] == BASE[ADDR_W-1:HI_LSB]);
        port_sel  = rd_addr_i[LANE_W +: PORT_W];
        lane_sel  = rd_addr_i[LANE_W-1:0];
        upper_sel = lane_sel - 1'b1;
    end

    // Upper-byte snapshots, refreshed by a read of the low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) snap_q[p] <= '0;
        end else if (rd_en_i && hit && lane_sel == '0) begin
            snap_q[port_sel] <= rx_time_i[port_sel][TIME_W-1:BYTE_W];
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_data_o <= '0;
        else if (rd_en_i && !hit)   rd_data_o <= '0;
        else if (rd_en_i) begin
            if (lane_sel == '0) rd_data_o <= rx_time_i[port_sel][BYTE_W-1:0];
            else                rd_data_o <= snap_q[port_sel][{upper_sel, 3'b000} +: BYTE_W];
        end
    end

    // R2: reads outside the window return zero.
    a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !hit) |=> (rd_data_o == '0));
endmodule

// File: rtl/rx_arrival_stamp.sv
// Top level of the frame arrival timestamp latch. One capture path per
// port, a write decoder that arms all ports, and a coherent byte-wide read
// path over the receive-time registers.
// Assumes all strobes are synchronous to clk.
module rx_arrival_stamp
    import rxt_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4,
    parameter int unsigned TIME_W    = 32,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE = 12'h900
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TIME_W-1:0]    local_time_i,
    input  logic [NUM_PORTS-1:0] sof_i,
    input  logic [NUM_PORTS-1:0] eof_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [BYTE_W-1:0]    rd_data_o
);
    localparam int unsigned BYTES = TIME_W / BYTE_W;

    logic              arm;
    logic [TIME_W-1:0] rx_time [NUM_PORTS];

    rxt_arm_decode #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BASE(BASE)) u_arm (
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .arm_o     (arm)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rxt_port_capture #(.TIME_W(TIME_W)) u_cap (
            .clk          (clk),
            .rst_n        (rst_n),
            .local_time_i (local_time_i),
            .sof_i        (sof_i[p]),
            .eof_i        (eof_i[p]),
            .arm_i        (arm),
            .rx_time_o    (rx_time[p])
        );

        // R5: a register can only change on that port's end-of-frame.
        a_r5_publish_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
            !eof_i[p] |=> $stable(rx_time[p]));
    end

    rxt_read_port #(
        .NUM_PORTS (NUM_PORTS),
        .TIME_W    (TIME_W),
        .ADDR_W    (ADDR_W),
        .BASE      (BASE)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .rx_time_i (rx_time),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: tb/rx_arrival_stamp_tb.sv
`timescale 1ns/1ps
module rx_arrival_stamp_tb;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] local_time = '0;
    logic [3:0]  sof = '0;
    logic [3:0]  eof = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [7:0]  rd_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    rx_arrival_stamp u_dut (
        .clk(clk), .rst_n(rst_n), .local_time_i(local_time),
        .sof_i(sof), .eof_i(eof), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    // Vector: {arm byte lane[1:0], port[1:0], start time[31:0]}
    localparam logic [35:0] VEC [0:5] = '{
        {2'd0, 2'd0, 32'h0000_1000},
        {2'd1, 2'd1, 32'hDEAD_BEEF},
        {2'd2, 2'd2, 32'h8000_0001},
        {2'd3, 2'd3, 32'hFFFF_FFFF},
        {2'd0, 2'd1, 32'h0123_4567},
        {2'd3, 2'd2, 32'h0000_00A5}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [11:0] a);
        @(negedge clk); wr_en = 1'b1; wr_addr = a;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic strobe(input logic [3:0] s, input logic [3:0] e, input logic [31:0] t);
        @(negedge clk); sof = s; eof = e; local_time = t;
        @(negedge clk); sof = '0; eof = '0; local_time = t + 32'd7;
    endtask

    task automatic read_byte(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic read_reg(input int p, output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            read_byte(12'h900 + 12'(4*p + i), b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic frame(input int p, input logic [31:0] t);
        strobe(4'(1 << p), 4'b0, t);
        idle(2);
        strobe(4'b0, 4'(1 << p), t + 32'd100);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        logic [31:0] keep;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1: reset values
        for (int p = 0; p < 4; p++) begin
            read_reg(p, v);
            check("R1 reset value", v, 32'h0);
        end

        // R3 R4 R5: table of armed measurements
        for (int i = 0; i < 6; i++) begin
            host_write(12'h900 + 12'(VEC[i][35:34]));
            idle(1);
            frame(int'(VEC[i][33:32]), VEC[i][31:0]);
            read_reg(int'(VEC[i][33:32]), v);
            check("R4 R5 armed capture", v, VEC[i][31:0]);
        end

        // R6: end-of-frame with no pending start on port 3
        strobe(4'b0, 4'b1000, 32'h5555_5555);
        read_reg(3, v);
        check("R6 orphan eof", v, 32'hFFFF_FFFF);

        // R10 R8: second frame on port 2 without re-arming
        frame(2, 32'h7777_0000);
        read_reg(2, v);
        check("R10 second frame ignored", v, 32'h0000_00A5);

        // R7: only port 0 sees a frame, port 3 keeps its value
        host_write(12'h902);
        idle(1);
        frame(0, 32'h0BAD_F00D);
        read_reg(0, v);
        check("R7 framed port updates", v, 32'h0BAD_F00D);
        read_reg(3, v);
        check("R7 idle port keeps value", v, 32'hFFFF_FFFF);

        // R3: write to port-1 register does not arm port 0
        host_write(12'h904);
        idle(1);
        frame(0, 32'h1111_2222);
        read_reg(0, v);
        check("R3 other address no arm", v, 32'h0BAD_F00D);

        // R9: coherent read across an update
        host_write(12'h900);
        idle(1);
        frame(2, 32'h1122_3344);
        read_byte(12'h908, b);
        check("R9 low byte", {24'h0, b}, 32'h44);
        host_write(12'h900);
        idle(1);
        frame(2, 32'hAABB_CCDD);
        keep = '0;
        for (int i = 1; i < 4; i++) begin
            read_byte(12'h908 + 12'(i), b);
            keep[8*i +: 8] = b;
        end
        check("R9 upper bytes from snapshot", keep, 32'h1122_3300);
        read_reg(2, v);
        check("R9 fresh full read", v, 32'hAABB_CCDD);

        // R2: reads outside the window
        read_byte(12'h910, b);
        check("R2 read above window", {24'h0, b}, 32'h0);
        read_byte(12'h8FF, b);
        check("R2 read below window", {24'h0, b}, 32'h0);

        // R4: simultaneous frames on all ports at distinct times
        host_write(12'h901);
        idle(1);
        strobe(4'b0011, 4'b0000, 32'h0000_0A00);
        strobe(4'b1100, 4'b0000, 32'h0000_0B00);
        strobe(4'b0000, 4'b1111, 32'h0000_0C00);
        for (int p = 0; p < 4; p++) begin
            read_reg(p, v);
            check("R4 multi-port capture", v, (p < 2) ? 32'h0000_0A00 : 32'h0000_0B00);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule